// File: doc/BRIEF.md
# NMEA Sentence Filter and Checksum Checker

This block sits behind a serial byte receiver and watches a stream of ASCII characters, at most one per clock, each qualified by a valid strobe. It frames the stream into NMEA 0183 sentences, recognises the five-character address that follows the leading `$`, and keeps only fix data (GPGGA), minimum navigation data (GPRMC) and course/speed data (GPVTG). All other sentence types are dropped without a trace on the outputs.

The address match and the XOR checksum run in the same pass over the bytes, so no sentence buffer is needed. The characters after the address and before the `*` are forwarded as payload, tagged with a type code, one cycle after they arrive. When the closing line feed arrives, a one-cycle verdict pulse reports whether the two hex digits after `*` agree with the computed checksum. A downstream field decoder uses the payload stream and then commits or discards its work on the verdict.

Top module: `nmea_filter`

## Requirements
- R1: A `$` (0x24) received in any state starts a new sentence and abandons any sentence in progress; the abandoned sentence produces no verdict.
- R2: The five characters after `$` are the address; only `GPGGA`, `GPRMC` and `GPVTG` are accepted, and any other address (for example `GPGSA`) produces neither payload nor a verdict.
- R3: The type code on `pay_type` and `sent_type` is 0 for GPGGA, 1 for GPRMC and 2 for GPVTG.
- R4: Every character of an accepted sentence after the address and before `*` (or before CR when there is no `*`) appears on `pay_byte` with `pay_valid` high in the cycle after it is captured; `$`, the address, `*`, the checksum digits, CR and LF never appear as payload.
- R5: The checksum is the XOR of every character strictly between `$` and `*`; `sent_ok` is high with the verdict when it equals the two hex digits after `*`, which may be upper case or lower case.
- R6: The verdict (`sent_done` high for exactly one cycle, with `sent_ok` and `sent_type`) appears in the cycle after the LF (0x0A) that directly follows a CR (0x0D); a CR followed by any other character abandons the sentence with no verdict.
- R7: A sentence may hold at most 82 characters counting from `$` through LF; an 82-character sentence is judged normally, and one whose character count reaches 83 is discarded with no verdict (payload already forwarded is not withdrawn).
- R8: A non-hex character in either checksum position, or any character between the second checksum digit and CR, makes the verdict a failure.
- R9: A sentence that reaches CR/LF without a `*` gets a verdict with `sent_ok` low.
- R10: Bytes presented with `in_valid` low are ignored, and bytes outside a sentence (before any `$` or after a verdict) cause no output.
- R11: After reset `pay_valid`, `sent_done` and `sent_ok` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_byte` for one cycle |
| in_byte | input | 8 | Received ASCII character |
| pay_valid | output | 1 | Payload character present |
| pay_byte | output | 8 | Payload character of an accepted sentence |
| pay_type | output | 2 | Type code of the sentence the payload belongs to |
| sent_done | output | 1 | One-cycle verdict pulse after LF |
| sent_ok | output | 1 | Checksum matched and sentence well formed |
| sent_type | output | 2 | Type code of the judged sentence |

## Verification
Every output is a register, so a payload character and the verdict are both due exactly one cycle after the edge that captures the causing byte. The bench drives bytes on the falling edge and a monitor samples the outputs on later falling edges, accumulating payload count, payload XOR, payload type mismatches and verdicts, which are compared once the line has gone quiet a few cycles after the last byte. Sentences are sent both back to back and with idle cycles carrying a `$` under a low strobe, so the timing holds at full rate and the ignored bytes are observed at the ports.

// File: rtl/nmea_pkg.sv
package nmea_pkg;

    localparam int ADDR_LEN = 5;
    localparam int N_KINDS  = 3;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_BODY,
        PH_CKHI,
        PH_CKLO,
        PH_TAIL,
        PH_LF
    } phase_t;

    // Character at position pos of the address belonging to type code kind.
    function automatic logic [7:0] addr_char(input int kind, input logic [2:0] pos);
        logic [8*ADDR_LEN-1:0] word;
        case (kind)
            0:       word = "GPGGA";
            1:       word = "GPRMC";
            default: word = "GPVTG";
        endcase
        return word[8*(ADDR_LEN-1-int'(pos)) +: 8];
    endfunction

endpackage

// File: rtl/nmea_hex_nibble.sv
module nmea_hex_nibble (
    input  logic [7:0] ch,
    output logic [3:0] val,
    output logic       is_hex
);
    always_comb begin
        val    = 4'h0;
        is_hex = 1'b1;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            val = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            val = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            val = 4'(ch - 8'h57);
        end else begin
            is_hex = 1'b0;
        end
    end
endmodule

// File: rtl/nmea_addr_match.sv
module nmea_addr_match
    import nmea_pkg::*;
#(
    parameter int KINDS = N_KINDS,
    parameter int KW    = (KINDS > 1) ? $clog2(KINDS) : 1
) (
    input  logic [7:0]       ch,
    input  logic [2:0]       pos,
    input  logic [KINDS-1:0] live_in,
    output logic [KINDS-1:0] live_out,
    output logic [KW-1:0]    kind
);
    // One comparator per wanted address; a candidate stays alive while
    // every character so far has matched.
    for (genvar k = 0; k < KINDS; k++) begin : g_cand
        assign live_out[k] = live_in[k] && (ch == addr_char(k, pos));
    end

    always_comb begin
        kind = '0;
        for (int k = KINDS - 1; k >= 0; k--) begin
            if (live_out[k]) kind = KW'(k);
        end
    end
endmodule

// File: rtl/nmea_filter.sv
module nmea_filter
    import nmea_pkg::*;
#(
    parameter int MAX_LEN = 82,
    parameter int KINDS   = N_KINDS,
    parameter int KW      = (KINDS > 1) ? $clog2(KINDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    output logic          pay_valid,
    output logic [7:0]    pay_byte,
    output logic [KW-1:0] pay_type,
    output logic          sent_done,
    output logic          sent_ok,
    output logic [KW-1:0] sent_type
);
    localparam int LW = $clog2(MAX_LEN + 2);

    typedef struct packed {
        phase_t          ph;
        logic [LW-1:0]   len;
        logic [2:0]      apos;
        logic [KINDS-1:0] live;
        logic [7:0]      sum;
        logic [7:0]      got;
        logic            bad;
        logic [KW-1:0]   kind;
        logic            pay_v;
        logic [7:0]      pay_b;
        logic            done;
        logic            ok;
    } state_t;

    state_t q, d;

    logic [KINDS-1:0] live_nx;
    logic [KW-1:0]    kind_nx;
    logic [3:0]       nib;
    logic             nib_ok;
    logic [LW-1:0]    len_nx;

    nmea_addr_match #(.KINDS(KINDS), .KW(KW)) u_match (
        .ch       (in_byte),
        .pos      (q.apos),
        .live_in  (q.live),
        .live_out (live_nx),
        .kind     (kind_nx)
    );

    nmea_hex_nibble u_nib (
        .ch     (in_byte),
        .val    (nib),
        .is_hex (nib_ok)
    );

    assign len_nx = q.len + LW'(1);

    always_comb begin
        d       = q;
        d.pay_v = 1'b0;
        d.done  = 1'b0;
        d.ok    = 1'b0;
        if (in_valid) begin
            if (in_byte == CH_DOLLAR) begin
                d.ph   = PH_ADDR;
                d.len  = LW'(1);
                d.apos = '0;
                d.live = '1;
                d.sum  = '0;
                d.got  = '0;
                d.bad  = 1'b0;
            end else if (q.ph != PH_IDLE && int'(len_nx) > MAX_LEN) begin
                d.ph = PH_IDLE;
            end else begin
                if (q.ph != PH_IDLE) d.len = len_nx;
                case (q.ph)
                    PH_ADDR: begin
                        d.sum  = q.sum ^ in_byte;
                        d.live = live_nx;
                        d.apos = q.apos + 3'd1;
                        if (live_nx == '0) begin
                            d.ph = PH_IDLE;
                        end else if (q.apos == 3'(ADDR_LEN - 1)) begin
                            d.ph   = PH_BODY;
                            d.kind = kind_nx;
                        end
                    end
                    PH_BODY: begin
                        if (in_byte == CH_STAR) begin
                            d.ph = PH_CKHI;
                        end else if (in_byte == CH_CR) begin
                            d.bad = 1'b1;
                            d.ph  = PH_LF;
                        end else begin
                            d.sum   = q.sum ^ in_byte;
                            d.pay_v = 1'b1;
                            d.pay_b = in_byte;
                        end
                    end
                    PH_CKHI: begin
                        d.got[7:4] = nib;
                        d.bad      = q.bad | ~nib_ok;
                        d.ph       = PH_CKLO;
                    end
                    PH_CKLO: begin
                        d.got[3:0] = nib;
                        d.bad      = q.bad | ~nib_ok;
                        d.ph       = PH_TAIL;
                    end
                    PH_TAIL: begin
                        if (in_byte == CH_CR) d.ph = PH_LF;
                        else                  d.bad = 1'b1;
                    end
                    PH_LF: begin
                        if (in_byte == CH_LF) begin
                            d.done = 1'b1;
                            d.ok   = ~q.bad && (q.got == q.sum);
                        end
                        d.ph = PH_IDLE;
                    end
                    default: d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pay_valid = q.pay_v;
    assign pay_byte  = q.pay_b;
    assign pay_type  = q.kind;
    assign sent_done = q.done;
    assign sent_ok   = q.ok;
    assign sent_type = q.kind;

    AST_DOLLAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == CH_DOLLAR) |=> (q.ph == PH_ADDR && !sent_done)); // R1

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (int'(pay_type) < KINDS)); // R3

    AST_PAY_NO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (pay_byte != CH_STAR && pay_byte != CH_DOLLAR && pay_byte != CH_CR)); // R4

    AST_VERDICT_AFTER_LF: assert property (@(posedge clk) disable iff (!rst_n)
        sent_done |-> $past(in_valid && in_byte == CH_LF)); // R6

    AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sent_done |=> !sent_done); // R6

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.len) <= MAX_LEN); // R7

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sent_ok |-> sent_done); // R5

endmodule

// File: tb/nmea_filter_tb.sv
module nmea_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {kind[14:13], body_len[12:6], mutation[5:3], gap[2], exp_done[1], exp_ok[0]}
    // kind 3 = GPGSA; mutations: 0 none, 1 wrong sum, 2 lower-case hex,
    // 3 no star, 4 non-hex digit, 5 extra char before CR, 6 LF replaced
    localparam logic [14:0] VECS [0:NV-1] = '{
        {2'd0, 7'd20, 3'd0, 1'b1, 1'b1, 1'b1},
        {2'd1, 7'd30, 3'd0, 1'b0, 1'b1, 1'b1},
        {2'd2, 7'd15, 3'd2, 1'b1, 1'b1, 1'b1},
        {2'd3, 7'd20, 3'd0, 1'b1, 1'b0, 1'b0},
        {2'd0, 7'd10, 3'd1, 1'b0, 1'b1, 1'b0},
        {2'd1, 7'd12, 3'd3, 1'b1, 1'b1, 1'b0},
        {2'd2, 7'd8,  3'd4, 1'b1, 1'b1, 1'b0},
        {2'd0, 7'd71, 3'd0, 1'b0, 1'b1, 1'b1},
        {2'd1, 7'd72, 3'd0, 1'b0, 1'b0, 1'b0},
        {2'd2, 7'd5,  3'd5, 1'b1, 1'b1, 1'b0},
        {2'd0, 7'd9,  3'd6, 1'b1, 1'b0, 1'b0},
        {2'd2, 7'd0,  3'd0, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       pay_valid, sent_done, sent_ok;
    logic [7:0] pay_byte;
    logic [1:0] pay_type, sent_type;

    int checks = 0, fails = 0;
    int pcnt = 0, dcnt = 0, terr = 0;
    logic [7:0] pxor = 8'h00;
    logic       last_ok = 1'b0;
    logic [1:0] last_type = 2'd0;
    logic [1:0] exp_kind = 2'd0;

    logic [7:0] sbuf [0:127];
    int         slen = 0;
    logic [7:0] body_xor = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmea_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_type(pay_type),
        .sent_done(sent_done), .sent_ok(sent_ok), .sent_type(sent_type)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_valid) begin
                pcnt++;
                pxor ^= pay_byte;
                if (pay_type != exp_kind) terr++;
            end
            if (sent_done) begin
                dcnt++;
                last_ok   = sent_ok;
                last_type = sent_type;
            end
        end
    end

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        pcnt = 0; dcnt = 0; terr = 0; pxor = 8'h00;
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] v, input bit lower);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lower ? 8'h57 : 8'h37) + {4'h0, v};
    endfunction

    task automatic push(input logic [7:0] c);
        sbuf[slen] = c;
        slen++;
    endtask

    task automatic build(input logic [1:0] kind, input int blen, input logic [2:0] mut);
        logic [39:0] addr;
        logic [7:0]  cs, c;
        case (kind)
            2'd0: addr = "GPGGA";
            2'd1: addr = "GPRMC";
            2'd2: addr = "GPVTG";
            default: addr = "GPGSA";
        endcase
        slen = 0; cs = 8'h00; body_xor = 8'h00;
        push(8'h24);
        for (int i = 0; i < 5; i++) begin
            c = addr[8*(4-i) +: 8];
            push(c); cs ^= c;
        end
        for (int i = 0; i < blen; i++) begin
            c = (i % 4 == 0) ? 8'h2C : 8'(8'h30 + (i * 7 + 3) % 10);
            push(c); cs ^= c; body_xor ^= c;
        end
        if (mut == 3'd1) cs ^= 8'h01;
        if (mut != 3'd3) begin
            push(8'h2A);
            push(mut == 3'd4 ? 8'h47 : hexch(cs[7:4], mut == 3'd2));
            push(hexch(cs[3:0], mut == 3'd2));
            if (mut == 3'd5) push(8'h5A);
        end
        push(8'h0D);
        push(mut == 3'd6 ? 8'h58 : 8'h0A);
    endtask

    task automatic send(input int from, input bit gap);
        for (int i = from; i < slen; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = sbuf[i];
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0; in_byte = 8'h24;   // ignored '$' under low strobe (R10)
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [1:0] kind, input int blen, input logic [2:0] mut);
        case (mut)
            3'd1, 3'd2: return "R5";
            3'd3:       return "R9";
            3'd4, 3'd5: return "R8";
            3'd6:       return "R6";
            default: begin
                if (kind == 2'd3) return "R2";
                if (blen >= 71)   return "R7";
                return "R5";
            end
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!pay_valid && !sent_done && !sent_ok, "R11 outputs low in reset",
            int'({pay_valid, sent_done, sent_ok}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!pay_valid && !sent_done && !sent_ok, "R11 outputs low after reset",
            int'({pay_valid, sent_done, sent_ok}), 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] kind;
            int         blen;
            logic [2:0] mut;
            int         exp_pay;
            string      t;
            kind = VECS[v][14:13];
            blen = int'(VECS[v][12:6]);
            mut  = VECS[v][5:3];
            t    = tag_of(kind, blen, mut);
            exp_kind = kind;
            exp_pay  = (kind == 2'd3) ? 0 : blen;
            build(kind, blen, mut);
            clear_mon();
            send(0, VECS[v][2]);
            chk(dcnt == int'(VECS[v][1]), {t, " verdict count"}, dcnt, int'(VECS[v][1]));
            if (VECS[v][1]) begin
                chk(last_ok == VECS[v][0], {t, " verdict"}, int'(last_ok), int'(VECS[v][0]));
                chk(last_type == kind, "R3 verdict type", int'(last_type), int'(kind));
            end
            chk(pcnt == exp_pay, "R4 payload count", pcnt, exp_pay);
            chk(pxor == ((kind == 2'd3) ? 8'h00 : body_xor), "R4 payload content",
                int'(pxor), int'((kind == 2'd3) ? 8'h00 : body_xor));
            chk(terr == 0, "R3 payload type", terr, 0);
        end

        // R1: '$' mid-sentence restarts; partial prefix gives no verdict
        build(2'd1, 14, 3'd0);
        exp_kind = 2'd1;
        clear_mon();
        sbuf[slen] = 8'h00;
        for (int i = slen - 1; i >= 0; i--) sbuf[i + 4] = sbuf[i];
        sbuf[0] = 8'h24; sbuf[1] = "G"; sbuf[2] = "P"; sbuf[3] = "G";
        slen += 4;
        send(0, 1'b0);
        chk(dcnt == 1, "R1 single verdict after restart", dcnt, 1);
        chk(last_ok == 1'b1, "R1 restarted sentence ok", int'(last_ok), 1);
        chk(last_type == 2'd1, "R1 restarted type", int'(last_type), 1);
        chk(pcnt == 14, "R1 payload of restarted sentence", pcnt, 14);

        // R10: characters outside any sentence cause no output
        clear_mon();
        slen = 0;
        push("x"); push(8'h2A); push("4"); push("A"); push(8'h0D); push(8'h0A); push(",");
        send(0, 1'b1);
        chk(dcnt == 0 && pcnt == 0, "R10 bytes outside sentence ignored", dcnt + pcnt, 0);

        // R2: GPGSV dropped after a partial match on GP
        clear_mon();
        slen = 0;
        push(8'h24); push("G"); push("P"); push("G"); push("S"); push("V");
        push(","); push("1"); push(8'h0D); push(8'h0A);
        send(0, 1'b0);
        chk(dcnt == 0 && pcnt == 0, "R2 GPGSV dropped", dcnt + pcnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule